// File: doc/BRIEF.md
# Accumulator requantize-and-pack unit

This block sits at the output of a matrix-multiply engine. It receives one 32-bit signed accumulator result per handshake and turns it into a signed 8-bit value. To do that it adds a bias, multiplies by a fixed-point multiplier, rounds and shifts right arithmetically, adds a zero point, and saturates. Every four 8-bit results are gathered into one 32-bit word, which goes out on a valid/ready stream towards the host.

The host loads bias and multiplier pairs into a small indexed table through a write port. The zero point, the shift and the mode are held on static configuration inputs. In tensor-wide mode, table entry 0 supplies the bias and multiplier for every result, as a fully connected layer needs. In per-channel mode, a channel counter steps through the entries, one per result, and wraps after the configured channel count, as a convolution layer needs. A last-flag on the input closes the current output word early and restarts the channel sequence.

The datapath is three register stages deep. A stalled output freezes every stage and drops input ready, so no result is lost or reordered.

Top module: `rq_pack`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1, and the next result packed goes to byte lane 0 with channel 0.
- R2: Each result equals sat8(((acc + bias) * mult + rnd) >>> shift + zero_point). Here rnd is 2^(shift-1) for shift > 0 and 0 for shift = 0, which gives round-half-up. The intermediate values are computed without overflow.
- R3: The saturation happens after the zero point is added and clamps to the range -128 to 127.
- R4: With cfg_per_chan = 0, every result uses the bias and multiplier of table entry 0. The other table entries have no effect.
- R5: With cfg_per_chan = 1, the k-th accepted result uses table entry k mod cfg_num_chan for both bias and multiplier.
- R6: After a result accepted with in_last = 1, the next result uses channel 0 again.
- R7: Four consecutive results form one output word. The earliest result goes in bits 7:0 and the latest in bits 31:24.
- R8: A result with in_last = 1 closes its word at once. Any byte lanes not yet filled are 0, and out_last is 1. Words closed by a full lane count without in_last carry out_last = 0.
- R9: If the result that completes a word is accepted at clock edge k, out_valid is 1 after edge k+2 and not after edge k+1.
- R10: While out_valid = 1 and out_ready = 0, in_ready is 0, and out_data and out_last hold. Results already in the pipeline emerge intact and in order once out_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_per_chan | input | 1 | 1 selects per-channel parameters, 0 selects entry 0 for all |
| cfg_num_chan | input | 5 | Channel count before the counter wraps |
| cfg_shift | input | 5 | Right-shift amount 0..31 |
| cfg_zero_point | input | 8 | Signed zero point added before saturation |
| prm_we | input | 1 | Table write enable |
| prm_idx | input | 4 | Table entry written |
| prm_bias | input | 32 | Signed bias for the entry |
| prm_mult | input | 16 | Signed multiplier for the entry |
| in_valid | input | 1 | Accumulator result valid |
| in_ready | output | 1 | Block can take a result |
| in_acc | input | 32 | Signed accumulator result |
| in_last | input | 1 | Final result of a tile |
| out_valid | output | 1 | Packed word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Four packed 8-bit results |
| out_last | output | 1 | Word closes a tile |

## Verification
The hardest state to reach is a stall with the pipeline full: one finished word held at the output and two more results caught in the inner stages. The stimulus holds out_ready low and issues six results back to back. The fifth and sixth are accepted before out_valid rises, so they sit frozen behind the held word. The bench then checks that the held word stays stable, that ready stays low, and that the partial final word arrives correctly once the stall is released. The channel restart is shown by a per-channel tile of seven results followed by a new tile whose first result must use channel 0.

// File: rtl/rq_pkg.sv
package rq_pkg;

    localparam int ACC_W  = 32;
    localparam int MULT_W = 16;
    localparam int BYTE_W = 8;
    localparam int SUM_W  = ACC_W + 1;
    localparam int PROD_W = SUM_W + MULT_W;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  bias;
        logic [MULT_W-1:0] mult;
        logic              last;
    } sel_stage_t;

    typedef struct packed {
        logic [PROD_W-1:0] prod;
        logic              last;
    } mul_stage_t;

    function automatic logic [BYTE_W-1:0] sat8(input logic signed [PROD_W-1:0] v);
        if (v > PROD_W'(127))
            return 8'h7f;
        else if (v < -PROD_W'(128))
            return 8'h80;
        else
            return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/rq_chan_sel.sv
module rq_chan_sel
    import rq_pkg::*;
#(
    parameter int MAX_CH = 16,
    localparam int CH_W  = $clog2(MAX_CH),
    localparam int CNT_W = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              per_chan,
    input  logic [CNT_W-1:0]  num_chan,
    input  logic              prm_we,
    input  logic [CH_W-1:0]   prm_idx,
    input  logic [ACC_W-1:0]  prm_bias,
    input  logic [MULT_W-1:0] prm_mult,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  in_acc,
    input  logic              in_last,
    output logic              s1_vld,
    output sel_stage_t        s1_q
);

    logic [ACC_W-1:0]  bias_tab [MAX_CH];
    logic [MULT_W-1:0] mult_tab [MAX_CH];
    logic [CH_W-1:0]   chan_q;
    logic [CH_W-1:0]   rd_idx;
    logic              accept;
    logic              wrap;

    assign accept = in_valid && adv;
    assign rd_idx = per_chan ? chan_q : '0;
    assign wrap   = (CNT_W'(chan_q) + CNT_W'(1)) >= num_chan;

    always_ff @(posedge clk) begin
        if (prm_we) begin
            bias_tab[prm_idx] <= prm_bias;
            mult_tab[prm_idx] <= prm_mult;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
        end else if (accept) begin
            chan_q <= (in_last || wrap) ? '0 : chan_q + CH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_q   <= '0;
        end else if (adv) begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_q.acc  <= in_acc;
                s1_q.bias <= bias_tab[rd_idx];
                s1_q.mult <= mult_tab[rd_idx];
                s1_q.last <= in_last;
            end
        end
    end

    AST_CHAN_RESTART: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last) |=> (chan_q == '0)) // R6
        else $error("channel counter did not restart after last");

endmodule

// File: rtl/rq_scale.sv
module rq_scale
    import rq_pkg::*;
#(
    parameter int SH_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [SH_W-1:0]   shift,
    input  logic [BYTE_W-1:0] zero_point,
    input  logic              s1_vld,
    input  sel_stage_t        s1_q,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic              byte_last
);

    mul_stage_t               s2_q;
    logic                     s2_vld;
    logic signed [SUM_W-1:0]  sum_c;
    logic signed [PROD_W-1:0] sum_w;
    logic signed [PROD_W-1:0] mult_w;
    logic signed [PROD_W-1:0] rnd_c;
    logic signed [PROD_W-1:0] prod_c;
    logic signed [PROD_W-1:0] shifted;
    logic signed [PROD_W-1:0] biased;

    always_comb begin
        sum_c  = SUM_W'($signed(s1_q.acc)) + SUM_W'($signed(s1_q.bias));
        sum_w  = PROD_W'(sum_c);
        mult_w = PROD_W'($signed(s1_q.mult));
        rnd_c  = (shift == '0) ? '0 : (PROD_W'(1) <<< (shift - SH_W'(1)));
        prod_c = sum_w * mult_w + rnd_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            s2_q   <= '0;
        end else if (adv) begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_q.prod <= prod_c;
                s2_q.last <= s1_q.last;
            end
        end
    end

    always_comb begin
        shifted   = $signed(s2_q.prod) >>> shift;
        biased    = shifted + PROD_W'($signed(zero_point));
        byte_val  = sat8(biased);
        byte_vld  = s2_vld;
        byte_last = s2_q.last;
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(s2_q) && $stable(s2_vld))) // R10
        else $error("multiply stage moved during stall");

endmodule

// File: rtl/rq_packer.sv
module rq_packer
    import rq_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LC_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              byte_last,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);

    logic [BYTE_W-1:0] lane_q [LANES];
    logic [LC_W-1:0]   lane_cnt;
    logic [WORD_W-1:0] word_nx;
    logic              close_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_nx[g*BYTE_W +: BYTE_W] =
            (LC_W'(g) < lane_cnt)  ? lane_q[g] :
            (LC_W'(g) == lane_cnt) ? byte_val  : '0;
    end

    assign close_w = byte_last || (lane_cnt == LC_W'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_cnt  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (adv) begin
            out_valid <= 1'b0;
            if (byte_vld) begin
                if (close_w) begin
                    out_data  <= word_nx;
                    out_last  <= byte_last;
                    out_valid <= 1'b1;
                    lane_cnt  <= '0;
                end else begin
                    lane_q[lane_cnt] <= byte_val;
                    lane_cnt         <= lane_cnt + LC_W'(1);
                end
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))) // R10
        else $error("output word changed while stalled");

    AST_LAST_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (adv && byte_vld && byte_last) |=> (out_valid && out_last)) // R8
        else $error("last result did not close a word");

endmodule

// File: rtl/rq_pack.sv
module rq_pack
    import rq_pkg::*;
#(
    parameter int MAX_CH = 16,
    parameter int LANES  = 4,
    parameter int SH_W   = 5,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int CNT_W  = $clog2(MAX_CH + 1),
    localparam int WORD_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_per_chan,
    input  logic [CNT_W-1:0]  cfg_num_chan,
    input  logic [SH_W-1:0]   cfg_shift,
    input  logic [BYTE_W-1:0] cfg_zero_point,
    input  logic              prm_we,
    input  logic [CH_W-1:0]   prm_idx,
    input  logic [ACC_W-1:0]  prm_bias,
    input  logic [MULT_W-1:0] prm_mult,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ACC_W-1:0]  in_acc,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);

    logic              adv;
    logic              s1_vld;
    sel_stage_t        s1_q;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic              byte_last;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    rq_chan_sel #(.MAX_CH(MAX_CH)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .per_chan (cfg_per_chan),
        .num_chan (cfg_num_chan),
        .prm_we   (prm_we),
        .prm_idx  (prm_idx),
        .prm_bias (prm_bias),
        .prm_mult (prm_mult),
        .in_valid (in_valid),
        .in_acc   (in_acc),
        .in_last  (in_last),
        .s1_vld   (s1_vld),
        .s1_q     (s1_q)
    );

    rq_scale #(.SH_W(SH_W)) u_scale (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .shift      (cfg_shift),
        .zero_point (cfg_zero_point),
        .s1_vld     (s1_vld),
        .s1_q       (s1_q),
        .byte_vld   (byte_vld),
        .byte_val   (byte_val),
        .byte_last  (byte_last)
    );

    rq_packer #(.LANES(LANES)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val),
        .byte_last (byte_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: tb/rq_pack_tb.sv
`timescale 1ns/1ps
module rq_pack_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_per_chan = 1'b0;
    logic [4:0]  cfg_num_chan = 5'd1;
    logic [4:0]  cfg_shift = 5'd0;
    logic [7:0]  cfg_zero_point = 8'd0;
    logic        prm_we = 1'b0;
    logic [3:0]  prm_idx = '0;
    logic [31:0] prm_bias = '0;
    logic [15:0] prm_mult = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_acc = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cap_data [16];
    logic        cap_last [16];
    int          cap_n = 0;

    always #5 clk = ~clk;

    rq_pack dut_i (
        .clk(clk), .rst(rst), .cfg_per_chan(cfg_per_chan), .cfg_num_chan(cfg_num_chan),
        .cfg_shift(cfg_shift), .cfg_zero_point(cfg_zero_point), .prm_we(prm_we),
        .prm_idx(prm_idx), .prm_bias(prm_bias), .prm_mult(prm_mult),
        .in_valid(in_valid), .in_ready(in_ready), .in_acc(in_acc), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    // per-tensor vectors: bias 10, mult 3, shift 2, zero point -5
    localparam logic [31:0] TV_ACC [12] = '{
        32'd2, -32'sd10, -32'sd11, 32'd1000, -32'sd1000, 32'd160,
        32'd162, -32'sd12, 32'h7fffffff, 32'h80000000, -32'sd9, -32'sd8};
    localparam logic [7:0] TV_EXP [12] = '{
        8'h04, 8'hfb, 8'hfa, 8'h7f, 8'h80, 8'h7b,
        8'h7c, 8'hfa, 8'h7f, 8'h80, 8'hfc, 8'hfd};

    // capture one cycle's accepted word, sampled after the negedge drivers settle
    always begin
        @(negedge clk);
        #1;
        if (!rst && out_valid && out_ready && cap_n < 16) begin
            cap_data[cap_n] = out_data;
            cap_last[cap_n] = out_last;
            cap_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cap_n = 0;
    endtask

    task automatic wr_prm(input int idx, input logic [31:0] b, input logic [15:0] m);
        @(negedge clk);
        prm_we = 1'b1; prm_idx = 4'(idx); prm_bias = b; prm_mult = m;
        @(negedge clk);
        prm_we = 1'b0;
    endtask

    // returns at the negedge following the accepting edge
    task automatic send(input logic [31:0] a, input logic l);
        in_valid = 1'b1; in_acc = a; in_last = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        @(negedge clk); #1;
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        check("R1 in_ready after reset", 32'(in_ready), 32'd1);

        // R4: entries 1 and 2 differ from entry 0 and must be ignored in tensor-wide mode
        wr_prm(0, 32'd10, 16'd3);
        wr_prm(1, 32'd0, 16'd100);
        wr_prm(2, 32'd50, -16'sd7);
        cfg_per_chan = 1'b0; cfg_num_chan = 5'd3; cfg_shift = 5'd2; cfg_zero_point = 8'hfb;

        // vector table: R2 rounding, R3 saturation, R4, R7 packing, R8 last
        for (int i = 0; i < 12; i++) send(TV_ACC[i], i == 11);
        idle(6);
        check("R7 word count", 32'(cap_n), 32'd3);
        for (int w = 0; w < 3; w++) begin
            check("R2 R3 R4 R7 table word",
                  cap_data[w], {TV_EXP[4*w+3], TV_EXP[4*w+2], TV_EXP[4*w+1], TV_EXP[4*w]});
            check("R8 table out_last", 32'(cap_last[w]), 32'(w == 2));
        end

        // R9 latency
        cap_n = 0;
        for (int i = 0; i < 3; i++) send(32'd2, 1'b0);
        send(32'd2, 1'b0);
        #1 check("R9 not valid after edge k", 32'(out_valid), 32'd0);
        @(negedge clk); #1;
        check("R9 not valid after edge k+1", 32'(out_valid), 32'd0);
        @(negedge clk); #1;
        check("R9 valid after edge k+2", 32'(out_valid), 32'd1);
        check("R9 latency word", out_data, 32'h04040404);
        idle(3);

        // R5 per-channel with wrap at 3, R8 zero padding
        do_reset();
        wr_prm(1, 32'd0, 16'd1);
        wr_prm(2, -32'sd100, 16'd2);
        cfg_per_chan = 1'b1; cfg_num_chan = 5'd3; cfg_shift = 5'd0; cfg_zero_point = 8'd0;
        for (int i = 0; i < 7; i++) send(32'd5, i == 6);
        idle(6);
        check("R5 word count", 32'(cap_n), 32'd2);
        check("R5 per-channel word 0", cap_data[0], 32'h2d80052d);
        check("R5 R8 padded word", cap_data[1], 32'h002d8005);
        check("R8 padded out_last", 32'(cap_last[1]), 32'd1);

        // R6 restart at channel 0 after last
        cap_n = 0;
        for (int i = 0; i < 4; i++) send(32'd5, i == 3);
        idle(6);
        check("R6 restart word", cap_data[0], 32'h2d80052d);

        // R10 backpressure with pipeline full
        do_reset();
        cfg_per_chan = 1'b0; cfg_shift = 5'd2; cfg_zero_point = 8'hfb;
        out_ready = 1'b0;
        for (int i = 0; i < 6; i++) send(TV_ACC[i], i == 5);
        idle(4);
        #1;
        check("R10 held valid", 32'(out_valid), 32'd1);
        check("R10 ready low", 32'(in_ready), 32'd0);
        check("R10 held data", out_data, 32'h7ffafb04);
        check("R10 nothing captured", 32'(cap_n), 32'd0);
        @(negedge clk);
        out_ready = 1'b1;
        idle(6);
        check("R10 words after release", 32'(cap_n), 32'd2);
        check("R10 first word", cap_data[0], 32'h7ffafb04);
        check("R10 R8 tail word", cap_data[1], 32'h00007b80);
        check("R10 R8 tail last", 32'(cap_last[1]), 32'd1);

        summary();
    end

endmodule